// File: doc/BRIEF.md
# Double-Buffered DAC Register Interface

This block is the digital front end of a 16-bit parallel-bus voltage DAC, written as synchronous logic in one system clock. A host reaches it through an active-low select, a read/write level, a write-data bus and a read-data bus with its own drive enable. The read-data bus and its enable are meant to be joined into one bidirectional pad set at the chip edge. The host writes a word into a staging register and can read that same word back to confirm it. An active-low load strobe copies the staged word into the conversion register, and that register drives the converter code. Several such blocks can share one load strobe, so their outputs change together.

An active-low clear forces the conversion register to one of two words. Which word depends on the read/write level, so zero volts can be reached in both unipolar and offset-binary bipolar use. A falling load strobe also starts a hold flag of fixed length, which freezes the analog output stage while the new code settles. If the load strobe is tied low for good, each write passes straight through to the converter code and no hold flag ever appears. All host controls are asynchronous. Each one, and the write bus with them, passes through a two-flop synchronizer before any decision is made. The interface is a plain strobed register port with no valid/ready handshake and no back-pressure: a write or read is done by holding the select low for at least four clock cycles.

Top module: `dac_bus_frontend`

## Requirements
- R1: While `rst` is high, and afterwards until a control input acts, `conv_code` is 0x0000, `bus_rdata_en` is 0, `bus_rdata` is 0 and `out_hold` is 0. A readback right after reset returns 0x0000.
- R2: While `host_sel_n` is low and `host_rd` is low, the staging register takes the word on `bus_wdata`. It is updated on the third rising clock edge after the inputs change. A later readback returns exactly the written word.
- R3: While `host_sel_n` is high, the staging register keeps its value whatever `bus_wdata` and `host_rd` do, and `bus_rdata_en` stays 0.
- R4: `bus_rdata_en` is 1 exactly when the two-cycle-delayed `host_sel_n` is low and `host_rd` is high. While it is 1, `bus_rdata` carries the staging register. While it is 0, `bus_rdata` is 0. It drops two cycles after either condition ends.
- R5: The conversion register changes only through a load or a clear. While `load_n` is high, writes to the staging register leave `conv_code` unchanged. While `load_n` is low, the staging register is copied into it, and the copy leaves the staging register unchanged.
- R6: With `load_n` held low from reset onwards, each written word appears on `conv_code` and `out_hold` never goes high.
- R7: While `clear_n` is low, `conv_code` becomes 0x0000 if `host_rd` is 0 and 0x8000 (only bit 15 set) if `host_rd` is 1. The staging register is not changed.
- R8: A clear overrides a load that is active in the same cycle. Once the clear ends and `load_n` is still low, the staging register is copied again.
- R9: A high-to-low transition of `load_n` raises `out_hold` from the third rising edge after the input falls, for exactly HOLD_CYCLES = floor(CLK_HZ·HOLD_NS/10^9) cycles, with a minimum of 1. A new falling edge during the hold restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Host select, active low, asynchronous |
| host_rd | input | 1 | 1 = read back / clear to mid-scale, 0 = write / clear to zero |
| load_n | input | 1 | Transfer staging word to conversion register, active low, asynchronous |
| clear_n | input | 1 | Clear conversion register, active low, asynchronous |
| bus_wdata | input | DATA_W | Write data from the host bus |
| bus_rdata | output | DATA_W | Readback data, zero when not driven |
| bus_rdata_en | output | 1 | Drive enable for the readback bus |
| conv_code | output | DATA_W | Code word to the converter |
| out_hold | output | 1 | Output-stage hold flag |

## Verification
The bench builds the block with the default 16-bit width and a 125 MHz clock, but shortens HOLD_NS to 80 ns, which gives a hold of 10 cycles. With that length the whole hold window, its first and last cycle, and a restart that stretches it to 16 cycles all fit in short observation loops. The full width keeps both clear words and a 64-word write/readback sweep of walking-one, walking-zero and spread patterns meaningful. A second reset with the load strobe held low gives the tied-low case, where no falling edge ever reaches the edge detector.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Synchronized host control bundle
  typedef struct packed {
    logic sel_n;
    logic rd;
    logic load_n;
    logic clear_n;
  } ctrl_t;

  // Reset value of the control synchronizer: deselected, load seen low so
  // a strobe tied low from reset never yields a falling edge.
  localparam ctrl_t CTRL_IDLE = '{sel_n: 1'b1, rd: 1'b0, load_n: 1'b0, clear_n: 1'b1};

  typedef enum logic [1:0] {
    ACT_KEEP    = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_CLR_ZERO = 2'd2,
    ACT_CLR_MID = 2'd3
  } conv_act_e;

  function automatic int hold_cycles(longint clk_hz, longint hold_ns);
    longint c;
    c = (clk_hz * hold_ns) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else if (i == 0) stage[i] <= d;
      else stage[i] <= stage[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dacfe_host_port.sv
module dacfe_host_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  logic wr_hit;

  assign wr_hit = !sel_n && !rd;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else if (wr_hit) stage_q <= wdata;
  end

  assign rdata_en = !sel_n && rd;
  assign rdata    = rdata_en ? stage_q : '0;
endmodule

// File: rtl/dacfe_conv_reg.sv
module dacfe_conv_reg
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic              rd,
  input  logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] code_q
);
  localparam logic [DATA_W-1:0] MID_WORD  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ZERO_WORD = '0;

  conv_act_e act;

  // Clear has priority over load
  always_comb begin
    if (!clear_n)     act = rd ? ACT_CLR_MID : ACT_CLR_ZERO;
    else if (!load_n) act = ACT_LOAD;
    else              act = ACT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else begin
      case (act)
        ACT_LOAD:     code_q <= stage_q;
        ACT_CLR_ZERO: code_q <= ZERO_WORD;
        ACT_CLR_MID:  code_q <= MID_WORD;
        default:      code_q <= code_q;
      endcase
    end
  end
endmodule

// File: rtl/dacfe_hold_timer.sv
module dacfe_hold_timer #(
  parameter int HOLD_CYCLES = 312
) (
  input  logic clk,
  input  logic rst,
  input  logic load_n,
  output logic hold
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);

  logic             load_n_d;
  logic             fall;
  logic [CNT_W-1:0] cnt;

  assign fall = load_n_d && !load_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_n_d <= 1'b0;
      cnt      <= '0;
    end else begin
      load_n_d <= load_n;
      if (fall)          cnt <= CNT_LOAD;
      else if (cnt != 0) cnt <= cnt - CNT_W'(1);
    end
  end

  assign hold = (cnt != 0);
endmodule

// File: rtl/dac_bus_frontend.sv
module dac_bus_frontend
  import dacfe_pkg::*;
#(
  parameter int     DATA_W  = 16,
  parameter longint CLK_HZ  = 125_000_000,
  parameter int     HOLD_NS = 2500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_rd,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_en,
  output logic [DATA_W-1:0] conv_code,
  output logic              out_hold
);
  localparam int HOLD_CYCLES = hold_cycles(CLK_HZ, longint'(HOLD_NS));
  localparam int CTRL_W      = $bits(ctrl_t);

  ctrl_t             ctrl_raw;
  ctrl_t             ctrl_s;
  logic [CTRL_W-1:0] ctrl_s_vec;
  logic [DATA_W-1:0] wdata_s;
  logic [DATA_W-1:0] stage_q;

  assign ctrl_raw = '{sel_n: host_sel_n, rd: host_rd, load_n: load_n, clear_n: clear_n};

  dacfe_sync #(.W(CTRL_W), .STAGES(2), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
    .clk (clk),
    .rst (rst),
    .d   (ctrl_raw),
    .q   (ctrl_s_vec)
  );
  assign ctrl_s = ctrl_t'(ctrl_s_vec);

  // Data follows the same delay so it lines up with the select
  dacfe_sync #(.W(DATA_W), .STAGES(2), .RST_VAL('0)) u_sync_data (
    .clk (clk),
    .rst (rst),
    .d   (bus_wdata),
    .q   (wdata_s)
  );

  dacfe_host_port #(.DATA_W(DATA_W)) u_host (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (ctrl_s.sel_n),
    .rd       (ctrl_s.rd),
    .wdata    (wdata_s),
    .stage_q  (stage_q),
    .rdata    (bus_rdata),
    .rdata_en (bus_rdata_en)
  );

  dacfe_conv_reg #(.DATA_W(DATA_W)) u_conv (
    .clk     (clk),
    .rst     (rst),
    .load_n  (ctrl_s.load_n),
    .clear_n (ctrl_s.clear_n),
    .rd      (ctrl_s.rd),
    .stage_q (stage_q),
    .code_q  (conv_code)
  );

  dacfe_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_n (ctrl_s.load_n),
    .hold   (out_hold)
  );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel_n,
  input logic              host_rd,
  input logic              load_n,
  input logic              clear_n,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rdata_en,
  input logic [DATA_W-1:0] conv_code,
  input logic              out_hold
);
  localparam logic [DATA_W-1:0] MID_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  // Cycles since reset, so no $past reaches back into reset
  logic [2:0] live;
  logic       warm;
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 3'd7) live <= live + 3'd1;
  end
  assign warm = (live >= 3'd5);

  // R4: undriven readback bus is zero
  p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata_en |-> (bus_rdata == '0));

  // R4, R3: enable follows the delayed select and read level
  p_rdata_en_r4: assert property (@(posedge clk) disable iff (rst)
    warm |-> (bus_rdata_en == (!$past(host_sel_n, 2) && $past(host_rd, 2))));

  // R5: conversion code moves only after a load or clear
  p_code_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (warm && !$stable(conv_code)) |-> (!$past(load_n, 3) || !$past(clear_n, 3)));

  // R7, R8: clear word chosen by read level, winning over load
  p_clear_word_r7: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(clear_n, 3)) |->
      (conv_code == ($past(host_rd, 3) ? MID_WORD : '0)));

  // R9, R6: hold only rises after a falling load strobe
  p_hold_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (warm && $rose(out_hold)) |-> (!$past(load_n, 3) && $past(load_n, 4)));
endmodule

bind dac_bus_frontend dacfe_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dac_bus_frontend.sv
`timescale 1ns/1ps
module tb_dac_bus_frontend;
  localparam int DW = 16;
  localparam int HOLD = 10; // 125 MHz * 80 ns

  logic          clk = 1'b0;
  logic          rst;
  logic          host_sel_n, host_rd, load_n, clear_n;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_rdata_en;
  logic [DW-1:0] conv_code;
  logic          out_hold;

  int n_chk = 0;
  int n_bad = 0;
  int hold_seen = 0;
  logic [DW-1:0] last_conv;
  logic [DW-1:0] rb;

  always #4 clk = ~clk;

  dac_bus_frontend #(.DATA_W(DW), .CLK_HZ(125_000_000), .HOLD_NS(80)) dut (
    .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_rd(host_rd),
    .load_n(load_n), .clear_n(clear_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_en(bus_rdata_en),
    .conv_code(conv_code), .out_hold(out_hold)
  );

  always @(negedge clk) if (out_hold) hold_seen++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [DW-1:0] w);
    bus_wdata = w; host_rd = 1'b0; host_sel_n = 1'b0;
    step(4);
    host_sel_n = 1'b1;
    step(3);
  endtask

  task automatic bus_read(output logic [DW-1:0] w);
    host_rd = 1'b1; host_sel_n = 1'b0;
    step(3);
    check("R4 enable during read", bus_rdata_en, 1);
    w = bus_rdata;
    host_sel_n = 1'b1;
    step(3);
    check("R4 enable released", bus_rdata_en, 0);
    check("R4 bus zero when idle", bus_rdata, 0);
    host_rd = 1'b0;
    step(1);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; step(4); load_n = 1'b1; step(3);
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int first, total, last;
    rst = 1'b1; host_sel_n = 1'b1; host_rd = 1'b0; load_n = 1'b1; clear_n = 1'b1;
    bus_wdata = '0;
    step(4);
    check("R1 code in reset", conv_code, 0);
    check("R1 hold in reset", out_hold, 0);
    rst = 1'b0;
    step(5);
    check("R1 code after reset", conv_code, 0);
    check("R1 enable after reset", bus_rdata_en, 0);
    check("R1 bus after reset", bus_rdata, 0);
    bus_read(rb);
    check("R1 readback after reset", rb, 0);
    last_conv = '0;

    // R2 / R5 sweep: writes with load idle leave conv_code alone
    for (int i = 0; i < 64; i++) begin
      logic [DW-1:0] w;
      if (i < 16)      w = DW'(1) << i;
      else if (i < 32) w = ~(DW'(1) << (i - 16));
      else             w = DW'((i - 32) * 40503 + 17);
      bus_write(w);
      bus_read(rb);
      check("R2 readback", rb, w);
      check("R5 conv unchanged by write", conv_code, last_conv);
    end

    // R3: deselected bus activity ignored
    bus_write(16'hA5C3);
    host_sel_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bus_wdata = DW'(i * 4369); host_rd = i[0];
      step(4);
      check("R3 enable stays low", bus_rdata_en, 0);
    end
    host_rd = 1'b0; step(3);
    bus_read(rb);
    check("R3 staging kept", rb, 16'hA5C3);

    // R5: transfer
    pulse_load();
    check("R5 transfer", conv_code, 16'hA5C3);
    bus_read(rb);
    check("R5 staging after transfer", rb, 16'hA5C3);
    bus_write(16'h1357);
    check("R5 conv held across write", conv_code, 16'hA5C3);
    pulse_load();
    check("R5 second transfer", conv_code, 16'h1357);

    // R7: clear words
    host_rd = 1'b0; clear_n = 1'b0; step(4); clear_n = 1'b1; step(3);
    check("R7 clear to zero", conv_code, 16'h0000);
    host_rd = 1'b1; clear_n = 1'b0; step(4); clear_n = 1'b1; step(3);
    host_rd = 1'b0; step(3);
    check("R7 clear to mid", conv_code, 16'h8000);
    bus_read(rb);
    check("R7 staging untouched", rb, 16'h1357);

    // R8: clear beats load
    bus_write(16'h1234);
    host_rd = 1'b1; clear_n = 1'b0; load_n = 1'b0;
    step(5);
    check("R8 clear wins", conv_code, 16'h8000);
    clear_n = 1'b1;
    step(5);
    check("R8 load resumes", conv_code, 16'h1234);
    load_n = 1'b1; host_rd = 1'b0;
    step(20);

    // R9: single hold window
    first = 0; total = 0; last = 0;
    load_n = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      if (k == 5) load_n = 1'b1;
      @(negedge clk);
      if (out_hold) begin
        if (first == 0) first = k;
        total++; last = k;
      end
    end
    check("R9 hold start", first, 3);
    check("R9 hold length", total, HOLD);
    check("R9 hold end", last, 2 + HOLD);

    // R9: restart during hold
    first = 0; total = 0; last = 0;
    load_n = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (k == 5) load_n = 1'b1;
      if (k == 7) load_n = 1'b0;
      if (k == 11) load_n = 1'b1;
      @(negedge clk);
      if (out_hold) begin
        if (first == 0) first = k;
        total++; last = k;
      end
    end
    check("R9 restart start", first, 3);
    check("R9 restart contiguous length", total, last - first + 1);
    check("R9 restart end", last, 8 + HOLD);

    // R6: load tied low from reset
    rst = 1'b1; load_n = 1'b0; step(3);
    rst = 1'b0; step(5);
    hold_seen = 0;
    bus_write(16'hBEEF);
    check("R6 pass-through first", conv_code, 16'hBEEF);
    bus_write(16'h0F0F);
    check("R6 pass-through second", conv_code, 16'h0F0F);
    step(15);
    check("R6 no hold", hold_seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule